// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read and write requests from an on-chip master into timed cycles on an asynchronous SRAM/ROM-style external bus. The two most significant address bits pick one of four address areas. Each area has its own active-low chip select, a wait-state count of 0 to 3 and a bus-width flag that selects 8 or 16 bits. A master raises `req_i` with address, direction, size and write data and holds them until `rdy_o` pulses. On that same cycle, read data is valid on `rdata_o`.

Every external access starts with a setup cycle. Programmed wait cycles follow, and then a strobe-end cycle. An external device can stretch the access with `xwait_i`, but the sequencer looks at that input only in the last programmed wait cycle. A halfword access to an 8-bit area is split into two byte cycles. The optional turnaround insertion places one dead cycle after a read when the next access is a write or goes to another area, so that a slow device does not collide with the next driver.

Settings are written through a small configuration port. After reset every area is 8 bits wide with 3 waits, and turnaround insertion is off.

Top module: `xbus_ctrl`

## Requirements
- R1: Address bits [ADDR_W-1:ADDR_W-2] select the area k. During an access only `cs_n_o[k]` is low and the other selects stay high.
- R2: At most one chip select is low at any time. All selects are high whenever no access is in progress, including the cycle after `rdy_o`.
- R3: With 0 waits on a non-split access, the select is low for exactly 2 cycles. `rdy_o` is high in the second of these cycles.
- R4: With a programmed wait count N on a non-split access, the select is low for N+2 cycles.
- R5: `xwait_i` (active high) is sampled only at the end of the last programmed wait cycle. Each sampled high adds one wait cycle. With N=0, or when it is high only in earlier cycles, it has no effect.
- R6: A halfword (`hw_i`=1) on a 16-bit area is one cycle carrying all of `xd_o`/`xd_i`[15:0] unchanged.
- R7: A halfword on an 8-bit area runs as two byte cycles. The first uses address bit 0 = 0 and carries bits [15:8]. The second uses bit 0 = 1 and carries bits [7:0]. `rdy_o` pulses once, after the second cycle, and the read result is {first byte, second byte}.
- R8: A byte access (`hw_i`=0) uses the given address and lane `xd[7:0]`. The read result is zero-extended.
- R9: A read holds `oe_n_o` low with `xd_oe_o` low. A write holds `xd_oe_o` high for the whole access and `we_n_o` low from the second cycle onward. `oe_n_o` and `we_n_o` are never low together, and neither is low outside a chip select.
- R10: With turnaround enabled, a read followed by a write, or by an access to a different area, gets one extra cycle before the select falls. Other sequences, or turnaround disabled, add none.
- R11: Under reset all selects, `oe_n_o` and `we_n_o` are high, `rdy_o` is low, and each area holds 3 waits at 8 bits.
- R12: A `cfg_we_i` pulse loads wait count and width for `cfg_area_i`. An `idle_we_i` pulse loads the turnaround enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until rdy_o |
| we_i | input | 1 | 1 = write, 0 = read |
| hw_i | input | 1 | 1 = halfword, 0 = byte |
| addr_i | input | ADDR_W | Byte address; top two bits pick the area |
| wdata_i | input | 16 | Write data (byte in [7:0]) |
| rdy_o | output | 1 | Access complete pulse |
| rdata_o | output | 16 | Read result, valid with rdy_o |
| cfg_we_i | input | 1 | Area configuration write strobe |
| cfg_area_i | input | 2 | Area being configured |
| cfg_waits_i | input | 2 | Wait-cycle count |
| cfg_wide_i | input | 1 | 1 = 16-bit area, 0 = 8-bit area |
| idle_we_i | input | 1 | Turnaround enable write strobe |
| idle_en_i | input | 1 | Turnaround enable value |
| xa_o | output | ADDR_W | External address |
| xd_o | output | 16 | External write data |
| xd_oe_o | output | 1 | External data drive enable |
| xd_i | input | 16 | External read data |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write strobe, active low |
| cs_n_o | output | 4 | Area chip selects, active low |
| xwait_i | input | 1 | External wait request, active high |

## Verification
The sequencer is exercised with reads and writes of each size to all four areas. Each area is configured with a different wait count and width, so a wrong area decode, a lost wait cycle or a missing byte split shows up as a wrong select-low length or wrong data. The external memory model returns data derived from the address, so the read results show which address was driven in each split half. Separate cases hold `xwait_i` high at a zero-wait area, high only before the last wait, and high across several final samples. Turnaround is tried with read-then-write, read-then-read in the same area, read-then-other-area and write-then-write, both enabled and disabled.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_T1,
    ST_TW,
    ST_T2
  } xst_e;

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs #(
  parameter int AREA_W = 2,
  parameter int WAIT_W = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cfg_we_i,
  input  logic [AREA_W-1:0]                      cfg_area_i,
  input  logic [WAIT_W-1:0]                      cfg_waits_i,
  input  logic                                   cfg_wide_i,
  input  logic                                   idle_we_i,
  input  logic                                   idle_en_i,
  output logic [(1<<AREA_W)-1:0][WAIT_W-1:0]     waits_o,
  output logic [(1<<AREA_W)-1:0]                 wide_o,
  output logic                                   idle_en_o
);

  localparam int AREAS = 1 << AREA_W;

  for (genvar k = 0; k < AREAS; k++) begin : g_area
    logic sel;
    assign sel = cfg_we_i && (cfg_area_i == AREA_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        waits_o[k] <= '1;
        wide_o[k]  <= 1'b0;
      end else if (sel) begin
        waits_o[k] <= cfg_waits_i;
        wide_o[k]  <= cfg_wide_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_en_o <= 1'b0;
    end else if (idle_we_i) begin
      idle_en_o <= idle_en_i;
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AREA_W = 2,
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              split_i,
  input  logic [WAIT_W-1:0] waits_i,
  input  logic              idle_en_i,
  input  logic              xwait_i,
  output xst_e              state_o,
  output logic              part_o,
  output logic              accept_o,
  output logic              done_o,
  output logic              we_o,
  output logic [AREA_W-1:0] area_o
);

  xst_e              state_q, state_n;
  logic [WAIT_W-1:0] cnt_q, cnt_n;
  logic [WAIT_W-1:0] wcfg_q;
  logic              split_q, we_q;
  logic [AREA_W-1:0] area_q;
  logic              part_q, part_n;
  logic              last_rd_q, last_rd_n;
  logic [AREA_W-1:0] last_area_q, last_area_n;
  logic              turn_need;

  assign turn_need = idle_en_i && last_rd_q && (we_i || (area_i != last_area_q));

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    part_n      = part_q;
    last_rd_n   = last_rd_q;
    last_area_n = last_area_q;
    accept_o    = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          part_n   = 1'b0;
          state_n  = turn_need ? ST_GAP : ST_T1;
        end
      end
      ST_GAP:  state_n = ST_T1;
      ST_T1: begin
        cnt_n   = wcfg_q;
        state_n = (wcfg_q == '0) ? ST_T2 : ST_TW;
      end
      ST_TW: begin
        if (cnt_q == WAIT_W'(1)) begin
          if (!xwait_i) state_n = ST_T2;
        end else begin
          cnt_n = cnt_q - WAIT_W'(1);
        end
      end
      ST_T2: begin
        if (split_q && !part_q) begin
          part_n  = 1'b1;
          state_n = ST_T1;
        end else begin
          done_o      = 1'b1;
          state_n     = ST_IDLE;
          last_rd_n   = !we_q;
          last_area_n = area_q;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      part_q      <= 1'b0;
      last_rd_q   <= 1'b0;
      last_area_q <= '0;
    end else begin
      state_q     <= state_n;
      cnt_q       <= cnt_n;
      part_q      <= part_n;
      last_rd_q   <= last_rd_n;
      last_area_q <= last_area_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcfg_q  <= '0;
      split_q <= 1'b0;
      we_q    <= 1'b0;
      area_q  <= '0;
    end else if (accept_o) begin
      wcfg_q  <= waits_i;
      split_q <= split_i;
      we_q    <= we_i;
      area_q  <= area_i;
    end
  end

  assign state_o = state_q;
  assign part_o  = part_q;
  assign we_o    = we_q;
  assign area_o  = area_q;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AREA_W = 2,
  parameter int WAIT_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic                     hw_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [15:0]              wdata_i,
  output logic                     rdy_o,
  output logic [15:0]              rdata_o,
  input  logic                     cfg_we_i,
  input  logic [AREA_W-1:0]        cfg_area_i,
  input  logic [WAIT_W-1:0]        cfg_waits_i,
  input  logic                     cfg_wide_i,
  input  logic                     idle_we_i,
  input  logic                     idle_en_i,
  output logic [ADDR_W-1:0]        xa_o,
  output logic [15:0]              xd_o,
  output logic                     xd_oe_o,
  input  logic [15:0]              xd_i,
  output logic                     oe_n_o,
  output logic                     we_n_o,
  output logic [(1<<AREA_W)-1:0]   cs_n_o,
  input  logic                     xwait_i
);

  localparam int AREAS  = 1 << AREA_W;
  localparam int BYTE_W = 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [AREAS-1:0][WAIT_W-1:0] waits;
  logic [AREAS-1:0]             wide;
  logic                         idle_en;

  xbus_cfg_regs #(.AREA_W(AREA_W), .WAIT_W(WAIT_W)) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_area_i (cfg_area_i),
    .cfg_waits_i(cfg_waits_i),
    .cfg_wide_i (cfg_wide_i),
    .idle_we_i  (idle_we_i),
    .idle_en_i  (idle_en_i),
    .waits_o    (waits),
    .wide_o     (wide),
    .idle_en_o  (idle_en)
  );

  logic [AREA_W-1:0] area_in;
  logic              split_in;
  xst_e              state;
  logic              part, accept, done, we_q;
  logic [AREA_W-1:0] area_q;

  assign area_in  = addr_i[ADDR_W-1 -: AREA_W];
  assign split_in = hw_i && !wide[area_in];

  xbus_seq #(.AREA_W(AREA_W), .WAIT_W(WAIT_W)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .req_i    (req_i),
    .we_i     (we_i),
    .area_i   (area_in),
    .split_i  (split_in),
    .waits_i  (waits[area_in]),
    .idle_en_i(idle_en),
    .xwait_i  (xwait_i),
    .state_o  (state),
    .part_o   (part),
    .accept_o (accept),
    .done_o   (done),
    .we_o     (we_q),
    .area_o   (area_q)
  );

  // request capture
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              hw_q, wide_q;
  logic [BYTE_W-1:0] hi_q;
  logic              split_q, active, hi_ld;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      hw_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      hw_q    <= hw_i;
      wide_q  <= wide[area_in];
    end
  end

  assign split_q = hw_q && !wide_q;
  assign active  = (state == ST_T1) || (state == ST_TW) || (state == ST_T2);
  assign hi_ld   = (state == ST_T2) && split_q && !part;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_ld) hi_q <= xd_i[BYTE_W-1:0];
  end

  // external side
  assign xa_o    = split_q ? {addr_q[ADDR_W-1:1], part} : addr_q;
  assign oe_n_o  = !(active && !we_q);
  assign we_n_o  = !(((state == ST_TW) || (state == ST_T2)) && we_q);
  assign xd_oe_o = active && we_q;

  always_comb begin
    if (hw_q && wide_q)  xd_o = wdata_q;
    else if (split_q && !part) xd_o = {{BYTE_W{1'b0}}, wdata_q[15:BYTE_W]};
    else                 xd_o = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
  end

  for (genvar k = 0; k < AREAS; k++) begin : g_cs
    assign cs_n_o[k] = !(active && (area_q == AREA_W'(k)));
  end

  // internal side
  assign rdy_o = done;

  always_comb begin
    if (hw_q && wide_q) rdata_o = xd_i;
    else if (hw_q)      rdata_o = {hi_q, xd_i[BYTE_W-1:0]};
    else                rdata_o = {{BYTE_W{1'b0}}, xd_i[BYTE_W-1:0]};
  end

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
  parameter int ADDR_W = 20,
  parameter int AREA_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [(1<<AREA_W)-1:0] cs_n_o,
  input logic                   oe_n_o,
  input logic                   we_n_o,
  input logic                   xd_oe_o,
  input logic                   rdy_o,
  input logic [ADDR_W-1:0]      xa_o
);

  localparam int AREAS = 1 << AREA_W;
  localparam logic [AREAS-1:0] NONE = '1;

  assert_one_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  assert_area_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o != NONE) |-> (cs_n_o == ~(AREAS'(1) << xa_o[ADDR_W-1 -: AREA_W])));

  assert_no_dual_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && !we_n_o));

  assert_drive_vs_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xd_oe_o |-> oe_n_o);

  assert_strobe_in_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_o || !we_n_o) |-> (cs_n_o != NONE));

  assert_min_two_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> ($past(cs_n_o) != NONE) && (cs_n_o != NONE));

  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> (cs_n_o == NONE));

endmodule

bind xbus_ctrl xbus_chk #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_o (cs_n_o),
  .oe_n_o (oe_n_o),
  .we_n_o (we_n_o),
  .xd_oe_o(xd_oe_o),
  .rdy_o  (rdy_o),
  .xa_o   (xa_o)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, hw_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        rdy_o;
  logic [15:0] rdata_o;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_area_i = '0, cfg_waits_i = '0;
  logic        cfg_wide_i = 1'b0, idle_we_i = 1'b0, idle_en_i = 1'b0;
  logic [19:0] xa_o;
  logic [15:0] xd_o, xd_i;
  logic        xd_oe_o, oe_n_o, we_n_o, xwait_i = 1'b0;
  logic [3:0]  cs_n_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit tb_wide [4];

  always #2.5 clk_i = ~clk_i;

  // external memory model: high lane = inverted low address byte
  assign xd_i = {~xa_o[7:0], xa_o[7:0]};

  xbus_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .hw_i(hw_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdy_o(rdy_o), .rdata_o(rdata_o),
    .cfg_we_i(cfg_we_i), .cfg_area_i(cfg_area_i), .cfg_waits_i(cfg_waits_i),
    .cfg_wide_i(cfg_wide_i), .idle_we_i(idle_we_i), .idle_en_i(idle_en_i),
    .xa_o(xa_o), .xd_o(xd_o), .xd_oe_o(xd_oe_o), .xd_i(xd_i),
    .oe_n_o(oe_n_o), .we_n_o(we_n_o), .cs_n_o(cs_n_o), .xwait_i(xwait_i)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_area(input logic [1:0] ar, input logic [1:0] w, input logic wd);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_area_i = ar; cfg_waits_i = w; cfg_wide_i = wd;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    tb_wide[ar] = wd;
  endtask

  task automatic set_idle(input logic en);
    @(negedge clk_i);
    idle_we_i = 1'b1; idle_en_i = en;
    @(negedge clk_i);
    idle_we_i = 1'b0;
  endtask

  function automatic logic [15:0] exp_rd(input logic [19:0] a, input logic hw);
    if (!hw)                 return {8'h00, a[7:0]};
    else if (tb_wide[a[19:18]]) return {~a[7:0], a[7:0]};
    else                     return {a[7:0] & 8'hFE, a[7:0] | 8'h01};
  endfunction

  // one access; assumes called at a negedge
  task automatic access(input logic we, input logic [19:0] a, input logic hw,
                        input logic [15:0] wd, input int cyc, input int lat,
                        input int drop_at, input string tg);
    int n = 0, pre = 0, guard = 0;
    bit csbad = 0, strbad = 0, got = 0;
    logic [15:0] rd = '0, lastd = '0;
    logic [7:0]  hib = '0;
    logic [19:0] lasta = '0;
    req_i = 1'b1; we_i = we; addr_i = a; hw_i = hw; wdata_i = wd;
    xwait_i = (drop_at != 0);
    while (!got && guard < 200) begin
      @(negedge clk_i);
      guard++;
      if (cs_n_o != 4'hF) begin
        n++;
        if (cs_n_o != ~(4'b0001 << a[19:18])) csbad = 1;
        if (n == drop_at) xwait_i = 1'b0;
      end else if (n == 0) begin
        pre++;
      end
      if (!we_n_o) begin
        lasta = xa_o; lastd = xd_o;
        if (!xa_o[0]) hib = xd_o[7:0];
        if (!xd_oe_o) strbad = 1;
      end
      if (we && !oe_n_o) strbad = 1;
      if (we && cs_n_o != 4'hF && !xd_oe_o) strbad = 1;
      if (!we && (!we_n_o || xd_oe_o)) strbad = 1;
      if (rdy_o) begin got = 1; rd = rdata_o; end
    end
    req_i = 1'b0; xwait_i = 1'b0;
    check(got, "R3", {tg, " ready seen"}, int'(got), 1);
    check(n == cyc, "R4", {tg, " select-low cycles"}, n, cyc);
    check(pre == lat, "R10", {tg, " cycles before select"}, pre, lat);
    check(!csbad, "R1", {tg, " area select"}, int'(csbad), 0);
    check(!strbad, "R9", {tg, " strobes"}, int'(strbad), 0);
    if (!we) begin
      check(rd == exp_rd(a, hw), hw ? (tb_wide[a[19:18]] ? "R6" : "R7") : "R8",
            {tg, " read data"}, rd, exp_rd(a, hw));
    end else if (hw && tb_wide[a[19:18]]) begin
      check(lastd == wd, "R6", {tg, " write data"}, lastd, wd);
    end else if (hw) begin
      check(hib == wd[15:8] && lastd[7:0] == wd[7:0] && lasta[0],
            "R7", {tg, " split write"}, {hib, lastd[7:0]}, wd);
    end else begin
      check(lastd[7:0] == wd[7:0] && lasta == a, "R8", {tg, " byte write"},
            lastd[7:0], wd[7:0]);
    end
    @(negedge clk_i);
    check(cs_n_o == 4'hF, "R2", {tg, " release"}, cs_n_o, 4'hF);
  endtask

  typedef struct packed {
    logic        we;
    logic [19:0] a;
    logic        hw;
    logic [15:0] wd;
    logic [7:0]  cyc;
  } vec_t;

  // areas: 0 = 0 waits/16b, 1 = 2 waits/8b, 2 = 1 wait/16b, 3 = 3 waits/8b
  localparam vec_t VEC [9] = '{
    '{1'b0, 20'h00124, 1'b1, 16'h0000, 8'd2},
    '{1'b1, 20'h00126, 1'b1, 16'hBEEF, 8'd2},
    '{1'b0, 20'h40030, 1'b1, 16'h0000, 8'd8},
    '{1'b1, 20'h40032, 1'b1, 16'h1234, 8'd8},
    '{1'b0, 20'h80041, 1'b0, 16'h0000, 8'd3},
    '{1'b1, 20'h80042, 1'b1, 16'hA55A, 8'd3},
    '{1'b0, 20'hC0007, 1'b0, 16'h0000, 8'd5},
    '{1'b1, 20'hC0008, 1'b0, 16'h00C3, 8'd5},
    '{1'b0, 20'hC0010, 1'b1, 16'h0000, 8'd10}
  };

  initial begin
    for (int k = 0; k < 4; k++) tb_wide[k] = 1'b0;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check(cs_n_o == 4'hF, "R11", "selects in reset", cs_n_o, 4'hF);
    check(oe_n_o && we_n_o, "R11", "strobes in reset", {oe_n_o, we_n_o}, 2'b11);
    check(!rdy_o, "R11", "ready in reset", rdy_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(cs_n_o == 4'hF && !xd_oe_o, "R2", "idle after reset", cs_n_o, 4'hF);
    // R11: reset config 3 waits, 8 bits -> split halfword 2*(3+2)
    access(1'b0, 20'h40050, 1'b1, 16'h0, 10, 0, 0, "R11 default cfg");

    // R12: program per-area settings
    set_area(2'd0, 2'd0, 1'b1);
    set_area(2'd1, 2'd2, 1'b0);
    set_area(2'd2, 2'd1, 1'b1);
    set_area(2'd3, 2'd3, 1'b0);

    foreach (VEC[i]) begin
      access(VEC[i].we, VEC[i].a, VEC[i].hw, VEC[i].wd, int'(VEC[i].cyc), 0, 0,
             $sformatf("R12 vec%0d", i));
    end

    // R5: WAIT handling
    access(1'b0, 20'h00200, 1'b1, 16'h0, 2, 0, 255, "R5 zero-wait ignores WAIT");
    access(1'b0, 20'hC0200, 1'b0, 16'h0, 5, 0, 3, "R5 early WAIT ignored");
    access(1'b0, 20'h80200, 1'b1, 16'h0, 6, 0, 5, "R5 WAIT extends by 3");
    access(1'b1, 20'h40200, 1'b0, 16'h0077, 7, 0, 6, "R5 WAIT on write");

    // R10: turnaround disabled then enabled
    access(1'b0, 20'h00300, 1'b1, 16'h0, 2, 0, 0, "R10 off read");
    access(1'b1, 20'h00302, 1'b1, 16'h1111, 2, 0, 0, "R10 off rd->wr");
    set_idle(1'b1);
    access(1'b0, 20'h00300, 1'b1, 16'h0, 2, 0, 0, "R10 on read");
    access(1'b1, 20'h00302, 1'b1, 16'h2222, 2, 1, 0, "R10 on rd->wr");
    access(1'b1, 20'h00304, 1'b1, 16'h3333, 2, 0, 0, "R10 on wr->wr");
    access(1'b0, 20'h00306, 1'b1, 16'h0, 2, 0, 0, "R10 on wr->rd");
    access(1'b0, 20'h00308, 1'b1, 16'h0, 2, 0, 0, "R10 on rd->rd same");
    access(1'b0, 20'h80308, 1'b1, 16'h0, 3, 1, 0, "R10 on rd->rd other");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule